// File: doc/BRIEF.md
# Writeback Pixel Format Packer

The block sits on a frame writeback path. It receives a stream of 32-bit ARGB pixels, 8 bits per channel with alpha in bits [31:24], red in [23:16], green in [15:8] and blue in [7:0]. It converts each pixel to a memory pixel format picked by a 4-bit code, then packs the results into 32-bit little-endian words with byte strobes, ready for a memory write port. A pixel is 2, 3 or 4 bytes wide. The first pixel of a run occupies the lowest bytes of a word, and a pixel that does not fit in the current word continues in the next one.

The format code, the alpha controls and the byte-lane enables are static while a frame streams. Alpha is either stored, optionally inverted, or replaced by a constant fill. The pixel marked last closes the frame: any partial word left over is written out padded with zeros. Both sides use valid/ready handshakes, and a word stays on the output until it is accepted.

Top module: `wb_pixel_packer`

## Requirements
- R1: Codes 12, 13, 14 and 15 give 32-bit pixels in channel orders A-B-G-R, A-R-G-B, B-G-R-A and R-G-B-A, listed from the most significant byte down to byte 0.
- R2: Codes 0, 1, 2 and 3 give 16-bit pixels with 4-bit fields in orders A-B-G-R, A-R-G-B, B-G-R-A and R-G-B-A, listed from the most significant bits down. Each field holds the top 4 bits of its channel.
- R3: Code 7 gives a 16-bit pixel {R[7:3], G[7:2], B[7:3]}. Code 6 gives {B[7:3], G[7:2], R[7:3]}.
- R4: Code 9 gives a 24-bit pixel {R,G,B} and code 8 gives {B,G,R}. Four such pixels fill three 32-bit words, written in stream order from byte 0 upward.
- R5: When alpha_en_i is 0, the alpha field of a 4444 or 8888 pixel is filled with the complement of alpha_inv_i, repeated across the whole field. The 565 and 888 pixels ignore the alpha controls.
- R6: When alpha_en_i is 1, the alpha field holds the input alpha, inverted bitwise when alpha_inv_i is 1.
- R7: Two 16-bit pixels share one word. The earlier pixel sits in bits [15:0].
- R8: After the last pixel, a partial word is emitted with zeros in the unfilled upper bytes. Its strobes cover only the filled bytes. A full word carries all four strobes before gating.
- R9: Strobe bit i of every word is cleared when byte_en_i[i] is 0. The data is unchanged.
- R10: Codes 4, 5, 10 and 11 accept pixels and produce no output word.
- R11: While out_valid_o is high and out_ready_i is low, out_data_o and out_strb_o hold their values. No pixel is lost or reordered.
- R12: During reset and right after it, out_valid_o is 0 and pix_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 4 | Memory format code |
| alpha_en_i | input | 1 | Store alpha from the pixel |
| alpha_inv_i | input | 1 | Invert the stored alpha, or select the fill value |
| byte_en_i | input | 4 | Per-lane store enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Input pixel accepted |
| pix_argb_i | input | 32 | Input pixel, ARGB 8:8:8:8 |
| pix_last_i | input | 1 | Last pixel of the frame |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_data_o | output | 32 | Packed word, little-endian |
| out_strb_o | output | 4 | Byte strobes |

## Verification
The assertions assume that fmt_i, alpha_en_i, alpha_inv_i and byte_en_i stay constant from the first pixel of a frame to the word that closes it. They also assume each frame ends with a pixel marked last. The stimulus changes the control fields only after the previous frame's last word has been collected. It drives pixels and out_ready_i a little after the rising edge and samples in the middle of the cycle. The stall test holds out_ready_i low long enough to fill both pipeline registers, then releases it.

// File: rtl/wb_pack_pkg.sv
package wb_pack_pkg;
  localparam int unsigned CH_W       = 8;
  localparam int unsigned PIX_W      = 4 * CH_W;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = WORD_BYTES * 8;
  localparam int unsigned RES_BYTES  = WORD_BYTES - 1;
  localparam int unsigned RES_W      = RES_BYTES * 8;
  localparam int unsigned NB_W       = 3;
  localparam int unsigned CNT_W      = 2;

  localparam logic [3:0] FMT_ABGR4444 = 4'd0;
  localparam logic [3:0] FMT_ARGB4444 = 4'd1;
  localparam logic [3:0] FMT_BGRA4444 = 4'd2;
  localparam logic [3:0] FMT_RGBA4444 = 4'd3;
  localparam logic [3:0] FMT_BGR565   = 4'd6;
  localparam logic [3:0] FMT_RGB565   = 4'd7;
  localparam logic [3:0] FMT_BGR888   = 4'd8;
  localparam logic [3:0] FMT_RGB888   = 4'd9;
  localparam logic [3:0] FMT_ABGR8888 = 4'd12;
  localparam logic [3:0] FMT_ARGB8888 = 4'd13;
  localparam logic [3:0] FMT_BGRA8888 = 4'd14;
  localparam logic [3:0] FMT_RGBA8888 = 4'd15;

  typedef struct packed {
    logic [WORD_W-1:0] bits;    // right-aligned, unused bytes zero
    logic [NB_W-1:0]   nbytes;  // 0 = drop
  } px_word_t;

  function automatic px_word_t fmt_convert(input logic [3:0] fmt,
                                           input logic [PIX_W-1:0] argb,
                                           input logic alpha_en,
                                           input logic alpha_inv);
    px_word_t   o;
    logic [7:0] a, r, g, b;
    a = alpha_en ? (argb[31:24] ^ {8{alpha_inv}}) : {8{~alpha_inv}};
    r = argb[23:16];
    g = argb[15:8];
    b = argb[7:0];
    o.bits   = '0;
    o.nbytes = '0;
    case (fmt)
      FMT_ABGR4444: begin o.bits = {16'h0, a[7:4], b[7:4], g[7:4], r[7:4]}; o.nbytes = 3'd2; end
      FMT_ARGB4444: begin o.bits = {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]}; o.nbytes = 3'd2; end
      FMT_BGRA4444: begin o.bits = {16'h0, b[7:4], g[7:4], r[7:4], a[7:4]}; o.nbytes = 3'd2; end
      FMT_RGBA4444: begin o.bits = {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]}; o.nbytes = 3'd2; end
      FMT_BGR565:   begin o.bits = {16'h0, b[7:3], g[7:2], r[7:3]};         o.nbytes = 3'd2; end
      FMT_RGB565:   begin o.bits = {16'h0, r[7:3], g[7:2], b[7:3]};         o.nbytes = 3'd2; end
      FMT_BGR888:   begin o.bits = {8'h0, b, g, r};                         o.nbytes = 3'd3; end
      FMT_RGB888:   begin o.bits = {8'h0, r, g, b};                         o.nbytes = 3'd3; end
      FMT_ABGR8888: begin o.bits = {a, b, g, r};                            o.nbytes = 3'd4; end
      FMT_ARGB8888: begin o.bits = {a, r, g, b};                            o.nbytes = 3'd4; end
      FMT_BGRA8888: begin o.bits = {b, g, r, a};                            o.nbytes = 3'd4; end
      FMT_RGBA8888: begin o.bits = {r, g, b, a};                            o.nbytes = 3'd4; end
      default: ;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/wb_pix_convert.sv
module wb_pix_convert
  import wb_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        fmt_i,
  input  logic              alpha_en_i,
  input  logic              alpha_inv_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_argb_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_bits_o,
  output logic [NB_W-1:0]   out_nb_o,
  output logic              out_last_o
);
  px_word_t          cv;
  logic              v_q, last_q;
  logic [WORD_W-1:0] bits_q;
  logic [NB_W-1:0]   nb_q;

  assign cv         = fmt_convert(fmt_i, in_argb_i, alpha_en_i, alpha_inv_i);
  assign in_ready_o = !v_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      last_q <= 1'b0;
      bits_q <= '0;
      nb_q   <= '0;
    end else if (in_ready_o) begin
      v_q <= in_valid_i;
      if (in_valid_i) begin
        bits_q <= cv.bits;
        nb_q   <= cv.nbytes;
        last_q <= in_last_i;
      end
    end
  end

  assign out_valid_o = v_q;
  assign out_bits_o  = bits_q;
  assign out_nb_o    = nb_q;
  assign out_last_o  = last_q;

  // R11: a staged pixel waits unchanged for the packer
  a_r11_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !out_ready_i) |=> (v_q && $stable(bits_q) && $stable(nb_q)));
endmodule

// File: rtl/wb_word_packer.sv
module wb_word_packer
  import wb_pack_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_BYTES-1:0] byte_en_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [WORD_W-1:0]     in_bits_i,
  input  logic [NB_W-1:0]       in_nb_i,
  input  logic                  in_last_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [WORD_W-1:0]     out_data_o,
  output logic [WORD_BYTES-1:0] out_strb_o
);
  localparam int unsigned STREAM_W = WORD_W + RES_W;

  logic [RES_W-1:0]      res_q;
  logic [CNT_W-1:0]      res_cnt_q;
  logic                  flush_q;
  logic                  out_valid_q;
  logic [WORD_W-1:0]     out_data_q;
  logic [WORD_BYTES-1:0] out_strb_q;

  logic [STREAM_W-1:0]   stream;
  logic [NB_W-1:0]       total;
  logic [NB_W-1:0]       rem;
  logic                  full_word, out_free, take;
  logic [WORD_BYTES-1:0] part_mask;

  assign stream    = ({{RES_W{1'b0}}, in_bits_i} << {res_cnt_q, 3'b000})
                   | {{WORD_W{1'b0}}, res_q};
  assign total     = {1'b0, res_cnt_q} + in_nb_i;
  assign rem       = total - NB_W'(WORD_BYTES);
  assign full_word = total >= NB_W'(WORD_BYTES);
  assign out_free  = !out_valid_q || out_ready_i;
  assign in_ready_o = !flush_q && (!full_word || out_free);
  assign take      = in_valid_i && in_ready_o;

  // lanes filled by a residual of res_cnt_q bytes
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign part_mask[i] = (i < int'(res_cnt_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q       <= '0;
      res_cnt_q   <= '0;
      flush_q     <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_strb_q  <= '0;
    end else begin
      if (out_valid_q && out_ready_i) out_valid_q <= 1'b0;
      if (flush_q) begin
        if (out_free) begin
          out_valid_q <= 1'b1;
          out_data_q  <= {{(WORD_W-RES_W){1'b0}}, res_q};
          out_strb_q  <= byte_en_i & part_mask;
          res_q       <= '0;
          res_cnt_q   <= '0;
          flush_q     <= 1'b0;
        end
      end else if (take) begin
        if (full_word) begin
          out_valid_q <= 1'b1;
          out_data_q  <= stream[WORD_W-1:0];
          out_strb_q  <= byte_en_i;
          res_q       <= stream[STREAM_W-1:WORD_W];
          res_cnt_q   <= rem[CNT_W-1:0];
          flush_q     <= in_last_i && (rem != '0);
        end else begin
          res_q       <= stream[RES_W-1:0];
          res_cnt_q   <= total[CNT_W-1:0];
          flush_q     <= in_last_i && (total != '0);
        end
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign out_strb_o  = out_strb_q;

  a_r11_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_q && !out_ready_i) |=> (out_valid_q && $stable(out_data_q) && $stable(out_strb_q)));

  // R8: a closing partial word never fills its top byte
  a_r8_flush_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && out_free) |=> (out_valid_q && out_data_q[WORD_W-1 -: 8] == 8'h00));
endmodule

// File: rtl/wb_pixel_packer.sv
module wb_pixel_packer
  import wb_pack_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  fmt_i,
  input  logic        alpha_en_i,
  input  logic        alpha_inv_i,
  input  logic [3:0]  byte_en_i,
  input  logic        pix_valid_i,
  output logic        pix_ready_o,
  input  logic [31:0] pix_argb_i,
  input  logic        pix_last_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_data_o,
  output logic [3:0]  out_strb_o
);
  logic              s0_valid, s0_ready, s0_last;
  logic [WORD_W-1:0] s0_bits;
  logic [NB_W-1:0]   s0_nb;

  wb_pix_convert u_convert (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fmt_i       (fmt_i),
    .alpha_en_i  (alpha_en_i),
    .alpha_inv_i (alpha_inv_i),
    .in_valid_i  (pix_valid_i),
    .in_ready_o  (pix_ready_o),
    .in_argb_i   (pix_argb_i),
    .in_last_i   (pix_last_i),
    .out_valid_o (s0_valid),
    .out_ready_i (s0_ready),
    .out_bits_o  (s0_bits),
    .out_nb_o    (s0_nb),
    .out_last_o  (s0_last)
  );

  wb_word_packer u_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_en_i   (byte_en_i),
    .in_valid_i  (s0_valid),
    .in_ready_o  (s0_ready),
    .in_bits_i   (s0_bits),
    .in_nb_i     (s0_nb),
    .in_last_i   (s0_last),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_strb_o  (out_strb_o)
  );

  a_r9_strb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_strb_o & ~byte_en_i) == 4'b0000));
endmodule

// File: tb/wb_pixel_packer_tb_top.sv
module wb_pixel_packer_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] PX = 32'hC35A96E1;
  // {fmt, alpha_en, alpha_inv, expected data, expected strobes}
  localparam logic [41:0] VEC [18] = '{
    {4'd13, 1'b1, 1'b0, 32'hC35A96E1, 4'hF},  // R1
    {4'd12, 1'b1, 1'b0, 32'hC3E1965A, 4'hF},  // R1
    {4'd14, 1'b1, 1'b0, 32'hE1965AC3, 4'hF},  // R1
    {4'd15, 1'b1, 1'b0, 32'h5A96E1C3, 4'hF},  // R1
    {4'd1,  1'b1, 1'b0, 32'h0000C59E, 4'h3},  // R2
    {4'd0,  1'b1, 1'b0, 32'h0000CE95, 4'h3},  // R2
    {4'd2,  1'b1, 1'b0, 32'h0000E95C, 4'h3},  // R2
    {4'd3,  1'b1, 1'b0, 32'h000059EC, 4'h3},  // R2
    {4'd7,  1'b1, 1'b0, 32'h00005CBC, 4'h3},  // R3
    {4'd6,  1'b1, 1'b0, 32'h0000E4AB, 4'h3},  // R3
    {4'd9,  1'b1, 1'b0, 32'h005A96E1, 4'h7},  // R4
    {4'd8,  1'b1, 1'b0, 32'h00E1965A, 4'h7},  // R4
    {4'd13, 1'b1, 1'b1, 32'h3C5A96E1, 4'hF},  // R6
    {4'd13, 1'b0, 1'b0, 32'hFF5A96E1, 4'hF},  // R5
    {4'd13, 1'b0, 1'b1, 32'h005A96E1, 4'hF},  // R5
    {4'd1,  1'b0, 1'b0, 32'h0000F59E, 4'h3},  // R5
    {4'd1,  1'b1, 1'b1, 32'h0000359E, 4'h3},  // R6
    {4'd9,  1'b0, 1'b1, 32'h005A96E1, 4'h7}   // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] fmt = 4'd13, byte_en = 4'hF;
  logic aen = 1'b1, ainv = 1'b0;
  logic pix_valid = 1'b0, pix_last = 1'b0, out_ready = 1'b1;
  logic [31:0] pix_argb = '0;
  logic pix_ready, out_valid;
  logic [31:0] out_data;
  logic [3:0] out_strb;

  int n_chk = 0, n_bad = 0, cap_n = 0;
  logic [31:0] cap_d [16];
  logic [3:0]  cap_s [16];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wb_pixel_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .alpha_en_i(aen), .alpha_inv_i(ainv),
    .byte_en_i(byte_en), .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .pix_argb_i(pix_argb), .pix_last_i(pix_last), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_strb_o(out_strb)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && cap_n < 16) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_strb;
      cap_n++;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] px, input logic last);
    pix_argb  = px;
    pix_last  = last;
    pix_valid = 1'b1;
    do @(negedge clk); while (!pix_ready);
    @(posedge clk); #1;
    pix_valid = 1'b0;
    pix_last  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic word(input int idx, input logic [31:0] d, input logic [3:0] s, input string req);
    chk(cap_n > idx, req, 32'(cap_n), 32'(idx + 1));
    if (cap_n > idx) begin
      chk(cap_d[idx] == d, req, cap_d[idx], d);
      chk(cap_s[idx] == s, req, 32'(cap_s[idx]), 32'(s));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12 valid in reset", 32'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 valid after reset", 32'(out_valid), 0);
    chk(pix_ready == 1'b1, "R12 ready after reset", 32'(pix_ready), 1);
    idle(1);

    foreach (VEC[i]) begin
      {fmt, aen, ainv} = VEC[i][41:36];
      cap_n = 0;
      send(PX, 1'b1);
      idle(6);
      word(0, VEC[i][35:4], VEC[i][3:0], $sformatf("R1-R6 vector %0d", i));
      chk(cap_n == 1, "R8 single word", 32'(cap_n), 1);
    end

    // R4: four 24-bit pixels make three words
    fmt = 4'd9; aen = 1'b1; ainv = 1'b0; cap_n = 0;
    send(32'h00112233, 1'b0);
    send(32'h00445566, 1'b0);
    send(32'h00778899, 1'b0);
    send(32'h00AABBCC, 1'b1);
    idle(6);
    chk(cap_n == 3, "R4 word count", 32'(cap_n), 3);
    word(0, 32'h66112233, 4'hF, "R4 w0");
    word(1, 32'h88994455, 4'hF, "R4 w1");
    word(2, 32'hAABBCC77, 4'hF, "R4 w2");

    // R8: full word followed by a two-byte residual
    cap_n = 0;
    send(32'h00112233, 1'b0);
    send(32'h00445566, 1'b1);
    idle(6);
    chk(cap_n == 2, "R8 flush count", 32'(cap_n), 2);
    word(0, 32'h66112233, 4'hF, "R8 w0");
    word(1, 32'h00004455, 4'h3, "R8 pad");

    // R7: two 565 pixels share a word
    fmt = 4'd7; cap_n = 0;
    send(32'h00FF0000, 1'b0);
    send(32'h000000FF, 1'b1);
    idle(6);
    chk(cap_n == 1, "R7 word count", 32'(cap_n), 1);
    word(0, 32'h001FF800, 4'hF, "R7 shared");

    // R9: lane gating
    byte_en = 4'b0101; fmt = 4'd13; cap_n = 0;
    send(PX, 1'b1);
    idle(6);
    word(0, PX, 4'b0101, "R9 full word");
    fmt = 4'd1; cap_n = 0;
    send(PX, 1'b1);
    idle(6);
    word(0, 32'h0000C59E, 4'b0001, "R9 partial word");
    byte_en = 4'hF;

    // R10: unused codes drop pixels
    foreach (VEC[i]) if (i < 4) begin
      fmt = (i == 0) ? 4'd4 : (i == 1) ? 4'd5 : (i == 2) ? 4'd10 : 4'd11;
      cap_n = 0;
      send(PX, 1'b0);
      send(PX, 1'b1);
      idle(6);
      chk(cap_n == 0, "R10 no output", 32'(cap_n), 0);
    end

    // R11: stall holds output and stops input
    fmt = 4'd13; cap_n = 0; out_ready = 1'b0;
    send(32'h01020304, 1'b0);
    send(32'h05060708, 1'b1);
    idle(3);
    @(negedge clk);
    chk(out_valid == 1'b1, "R11 valid held", 32'(out_valid), 1);
    chk(out_data == 32'h01020304, "R11 data held", out_data, 32'h01020304);
    chk(pix_ready == 1'b0, "R11 input stalled", 32'(pix_ready), 0);
    repeat (3) @(negedge clk);
    chk(out_data == 32'h01020304 && out_strb == 4'hF, "R11 still held", out_data, 32'h01020304);
    @(posedge clk); #1;
    out_ready = 1'b1;
    idle(6);
    chk(cap_n == 2, "R11 no loss", 32'(cap_n), 2);
    word(0, 32'h01020304, 4'hF, "R11 order w0");
    word(1, 32'h05060708, 4'hF, "R11 order w1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule